// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command and address pins of a synchronous DRAM from reset until the memory can take normal traffic. Clock enable and all data-mask lines stay high throughout, and every cycle carries a NOP command unless the sequence places a real command there.

The sequence has a fixed order. First comes a stabilization wait whose length is derived from the clock frequency. Then one precharge-all command, a wait for the row precharge time, and a parameterized series of auto-refresh commands spaced by the refresh cycle time. Last comes a mode-register write built from the burst length, burst type, CAS latency and write-mode inputs. A ready flag rises once the mode-set recovery time has passed. If the requested mode uses a reserved code, the write is suppressed and an error flag is raised.

The mode inputs must stay stable from reset release until ready or error. They are judged in the cycle the mode write would be issued.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and after it, `cke_o` and every `dqm_o` bit are 1. Every cycle without a sequence command issues NOP, encoded {cs_n,ras_n,cas_n,we_n}=0111.
- R2: The stabilization wait is STAB_CYC = ceil(CLK_KHZ*STAB_US/1000) cycles. Cycle 0 is the first cycle after reset release, and cycles 0 to STAB_CYC-1 are all NOP.
- R3: In cycle STAB_CYC exactly one precharge-all is issued, encoded 0010, with address bit A10=1 and bank address 0. No other precharge follows.
- R4: The first auto-refresh is issued exactly T_RP cycles after the precharge-all.
- R5: The block issues max(REF_COUNT,8) auto-refresh commands, encoded 0001, each exactly T_RC cycles after the one before.
- R6: The mode write, encoded 0000, comes exactly T_RC cycles after the last refresh. It drives BL on A2..A0, BT on A3, CL on A6..A4 and WM on A9, with A8..A7, A11..A10 and the bank address at 0.
- R7: Legal burst-length codes are 000, 001, 010 and 011 with either burst type, plus 111 only with BT=0. Legal CAS latency codes are 010 and 011 only.
- R8: With an illegal mode, no mode write is issued. `err_o` rises in the cycle the mode write would have gone out and stays high, `ready_o` stays low, and the bus stays at NOP.
- R9: `ready_o` rises exactly T_RSC cycles after the mode write and stays high. Only NOPs follow the mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bl_i | input | 3 | Burst length code |
| bt_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cl_i | input | 3 | CAS latency code |
| wm_i | input | 1 | Write mode: 0 burst, 1 single location |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | DQM_W | Data masks |
| ready_o | output | 1 | Initialization complete |
| err_o | output | 1 | Reserved mode code requested |

## Verification
Two things happen in the same cycle: the end of the recovery wait after the final refresh, and the legality check of the mode inputs. That cycle either carries the mode write or starts the error state. The bench provokes this with boundary codes: full page with interleaved type, a reserved latency and a reserved burst length, alongside legal full-page and interleaved settings. It judges the outcome by the exact cycle in which the mode write or `err_o` appears and by the command seen in that cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_STAB, ST_PRE, ST_TRP, ST_REF, ST_TRC, ST_MRS, ST_TRSC, ST_READY, ST_ERR
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = '{1'b0, 1'b1, 1'b1, 1'b1};
  localparam cmd_t CMD_PRE = '{1'b0, 1'b0, 1'b1, 1'b0};
  localparam cmd_t CMD_REF = '{1'b0, 1'b0, 1'b0, 1'b1};
  localparam cmd_t CMD_MRS = '{1'b0, 1'b0, 1'b0, 1'b0};

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R2

endmodule

// File: rtl/sdram_mode_enc.sv
module sdram_mode_enc #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        bl_i,
  input  logic              bt_i,
  input  logic [2:0]        cl_i,
  input  logic              wm_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              legal_o
);

  logic bl_ok, cl_ok;

  always_comb begin
    word_o      = '0;
    word_o[2:0] = bl_i;
    word_o[3]   = bt_i;
    word_o[6:4] = cl_i;
    word_o[9]   = wm_i;
  end

  always_comb begin
    unique case (bl_i)
      3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      3'b111:                         bl_ok = !bt_i;  // full page: sequential only
      default:                        bl_ok = 1'b0;
    endcase
    cl_ok   = (cl_i == 3'b010) || (cl_i == 3'b011);
    legal_o = bl_ok && cl_ok;
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int STAB_US   = 500,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RSC     = 2,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 12,
  parameter int DQM_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bl_i,
  input  logic              bt_i,
  input  logic [2:0]        cl_i,
  input  logic              wm_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              ready_o,
  output logic              err_o
);

  localparam int STAB_CYC = (CLK_KHZ * STAB_US + 999) / 1000;
  localparam int REF_N    = imax(REF_COUNT, 8);
  localparam int MAX_WAIT = imax(STAB_CYC, imax(T_RC, imax(T_RP, T_RSC)));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int RC_W     = $clog2(REF_N + 1);

  init_state_e       state_q, state_d;
  logic [RC_W-1:0]   ref_cnt_q;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_legal;
  cmd_t              cmd;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(STAB_CYC - 1)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sdram_mode_enc #(.ADDR_W(ADDR_W)) u_mode (
    .bl_i    (bl_i),
    .bt_i    (bt_i),
    .cl_i    (cl_i),
    .wm_i    (wm_i),
    .word_o  (mode_word),
    .legal_o (mode_legal)
  );

  // wait states last (T-1) cycles so commands land exactly T apart
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_STAB: if (tmr_done) state_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 2);
        state_d  = ST_TRP;
      end
      ST_TRP: if (tmr_done) state_d = ST_REF;
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RC - 2);
        state_d  = ST_TRC;
      end
      ST_TRC: if (tmr_done) begin
        if (ref_cnt_q == RC_W'(REF_N)) state_d = mode_legal ? ST_MRS : ST_ERR;
        else                           state_d = ST_REF;
      end
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RSC - 2);
        state_d  = ST_TRSC;
      end
      ST_TRSC: if (tmr_done) state_d = ST_READY;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_STAB;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_q)
      ST_PRE: begin
        cmd        = CMD_PRE;
        addr_o[10] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin
        cmd    = CMD_MRS;
        addr_o = mode_word;
      end
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o   = 1'b1;
  assign dqm_o   = '1;
  assign ready_o = (state_q == ST_READY);
  assign err_o   = (state_q == ST_ERR);

  // ---------------- checker state ----------------
  localparam int GAP_MAX = imax(T_RP, imax(T_RC, T_RSC)) + 1;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  cmd_t             chk_issued, chk_last_q;
  logic [GAP_W-1:0] chk_gap_q;
  logic [RC_W:0]    chk_refs_q;
  logic [1:0]       chk_pres_q;

  assign chk_issued = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_last_q <= CMD_NOP;
      chk_gap_q  <= GAP_W'(GAP_MAX);
      chk_refs_q <= '0;
      chk_pres_q <= '0;
    end else begin
      if (chk_issued != CMD_NOP) begin
        chk_last_q <= chk_issued;
        chk_gap_q  <= GAP_W'(1);
      end else if (chk_gap_q != GAP_W'(GAP_MAX)) begin
        chk_gap_q <= chk_gap_q + 1'b1;
      end
      if (chk_issued == CMD_REF && chk_refs_q != '1) chk_refs_q <= chk_refs_q + 1'b1;
      if (chk_issued == CMD_PRE && chk_pres_q != '1) chk_pres_q <= chk_pres_q + 1'b1;
    end
  end

  AST_SINGLE_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_issued == CMD_PRE) |-> (chk_pres_q == '0)); // R3
  AST_REF_AFTER_TRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_issued == CMD_REF && chk_last_q == CMD_PRE) |-> (chk_gap_q >= GAP_W'(T_RP))); // R4
  AST_REF_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chk_issued == CMD_REF || chk_issued == CMD_MRS) && chk_last_q == CMD_REF)
      |-> (chk_gap_q >= GAP_W'(T_RC))); // R5
  AST_MRS_REF_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_issued == CMD_MRS) |-> (chk_refs_q >= (RC_W + 1)'(REF_N))); // R5
  AST_ERR_NO_MRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (chk_issued == CMD_NOP && !ready_o)); // R8
  AST_READY_AFTER_TRSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (chk_last_q == CMD_MRS && chk_gap_q >= GAP_W'(T_RSC))); // R9
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R9

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 1000;
  localparam int STAB_US    = 500;
  localparam int T_RP       = 3;
  localparam int T_RC       = 7;
  localparam int T_RSC      = 2;
  localparam int REF_COUNT  = 4;   // clamped to 8 by the design
  localparam int ADDR_W     = 12;
  localparam int DQM_W      = 8;
  localparam int STAB_CYC   = (CLK_KHZ * STAB_US + 999) / 1000;
  localparam int REF_EXP    = 8;
  localparam int MRS_CYC    = STAB_CYC + T_RP + REF_EXP * T_RC;
  localparam int NCYC       = MRS_CYC + T_RSC + 30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        bl = 3'b000, cl = 3'b010;
  logic              bt = 1'b0, wm = 1'b0;
  logic              cs_n, ras_n, cas_n, we_n, cke, ready, err;
  logic [1:0]        ba;
  logic [ADDR_W-1:0] addr;
  logic [DQM_W-1:0]  dqm;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_init_seq #(
    .CLK_KHZ(CLK_KHZ), .STAB_US(STAB_US), .T_RP(T_RP), .T_RC(T_RC), .T_RSC(T_RSC),
    .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .DQM_W(DQM_W)
  ) u_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .bl_i(bl), .bt_i(bt), .cl_i(cl), .wm_i(wm),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .cke_o(cke), .dqm_o(dqm), .ready_o(ready), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one full sequence and checks it against the expected timeline.
  task automatic run_case(input logic [2:0] bl_v, input logic bt_v,
                          input logic [2:0] cl_v, input logic wm_v, input bit legal);
    int first_cmd, pre_cnt, pre_cyc, ref_cnt, first_ref, bad_gap, prev_ref;
    int mrs_cnt, mrs_cyc, mrs_addr, mrs_ba, pre_a10, pre_ba;
    int rdy_cyc, err_cyc, pins_bad, rdy_drop, err_drop, post_cmd, bogus;
    int exp_addr;
    first_cmd = -1; pre_cnt = 0; pre_cyc = -1; ref_cnt = 0; first_ref = -1;
    bad_gap = 0; prev_ref = -1; mrs_cnt = 0; mrs_cyc = -1; mrs_addr = -1; mrs_ba = -1;
    pre_a10 = -1; pre_ba = -1; rdy_cyc = -1; err_cyc = -1; pins_bad = 0;
    rdy_drop = 0; err_drop = 0; post_cmd = 0; bogus = 0;

    rst_n = 1'b0;
    bl = bl_v; bt = bt_v; cl = cl_v; wm = wm_v;
    repeat (3) @(negedge clk);
    #1;
    check(cke === 1'b1 && dqm === '1, "R1 reset cke/dqm", {cke, dqm}, {1'b1, {DQM_W{1'b1}}});
    check({cs_n, ras_n, cas_n, we_n} === 4'b0111, "R1 reset NOP",
          int'({cs_n, ras_n, cas_n, we_n}), 7);
    check(ready === 1'b0 && err === 1'b0, "R9 reset ready/err low", int'({ready, err}), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NCYC; k++) begin
      #1;
      if (cke !== 1'b1 || dqm !== '1) pins_bad++;
      case ({cs_n, ras_n, cas_n, we_n})
        4'b0111: ;
        4'b0010: begin
          pre_cnt++; pre_cyc = k; pre_a10 = addr[10]; pre_ba = ba;
          if (first_cmd < 0) first_cmd = k;
        end
        4'b0001: begin
          if (first_cmd < 0) first_cmd = k;
          if (first_ref < 0) first_ref = k;
          else if (k - prev_ref != T_RC) bad_gap++;
          prev_ref = k; ref_cnt++;
        end
        4'b0000: begin
          if (first_cmd < 0) first_cmd = k;
          mrs_cnt++; mrs_cyc = k; mrs_addr = addr; mrs_ba = ba;
        end
        default: bogus++;
      endcase
      if (mrs_cnt > 0 && k > mrs_cyc && {cs_n, ras_n, cas_n, we_n} !== 4'b0111) post_cmd++;
      if (ready === 1'b1 && rdy_cyc < 0) rdy_cyc = k;
      if (rdy_cyc >= 0 && ready !== 1'b1) rdy_drop++;
      if (err === 1'b1 && err_cyc < 0) err_cyc = k;
      if (err_cyc >= 0 && (err !== 1'b1 || ready !== 1'b0)) err_drop++;
      @(negedge clk);
    end

    exp_addr = (int'(wm_v) << 9) | (int'(cl_v) << 4) | (int'(bt_v) << 3) | int'(bl_v);

    check(pins_bad == 0, "R1 cke/dqm held high", pins_bad, 0);
    check(bogus == 0, "R1 only known commands", bogus, 0);
    check(first_cmd == STAB_CYC, "R2 stabilization length", first_cmd, STAB_CYC);
    check(pre_cnt == 1 && pre_cyc == STAB_CYC, "R3 single precharge-all", pre_cnt, 1);
    check(pre_a10 == 1 && pre_ba == 0, "R3 precharge A10/BA", pre_a10 * 4 + pre_ba, 4);
    check(first_ref == STAB_CYC + T_RP, "R4 first refresh after tRP", first_ref, STAB_CYC + T_RP);
    check(ref_cnt == REF_EXP, "R5 refresh count", ref_cnt, REF_EXP);
    check(bad_gap == 0, "R5 refresh spacing tRC", bad_gap, 0);
    if (legal) begin
      check(mrs_cnt == 1 && mrs_cyc == MRS_CYC, "R6 mode write cycle", mrs_cyc, MRS_CYC);
      check(mrs_addr == exp_addr, "R6 mode word", mrs_addr, exp_addr);
      check(mrs_ba == 0, "R6 mode bank address", mrs_ba, 0);
      check(err_cyc < 0, "R7 legal code no error", err_cyc, -1);
      check(rdy_cyc == MRS_CYC + T_RSC, "R9 ready after tRSC", rdy_cyc, MRS_CYC + T_RSC);
      check(rdy_drop == 0, "R9 ready held", rdy_drop, 0);
      check(post_cmd == 0, "R9 NOP after mode write", post_cmd, 0);
    end else begin
      check(mrs_cnt == 0, "R8 no mode write on reserved code", mrs_cnt, 0);
      check(err_cyc == MRS_CYC, "R8 error cycle", err_cyc, MRS_CYC);
      check(err_drop == 0, "R8 error held, ready low", err_drop, 0);
      check(rdy_cyc < 0, "R7 reserved code never ready", rdy_cyc, -1);
    end
  endtask

  task automatic test_seq_bl8_cl2();     run_case(3'b011, 1'b0, 3'b010, 1'b0, 1'b1); endtask
  task automatic test_full_page_seq();   run_case(3'b111, 1'b0, 3'b011, 1'b1, 1'b1); endtask
  task automatic test_interleaved_bl4(); run_case(3'b010, 1'b1, 3'b011, 1'b0, 1'b1); endtask
  task automatic test_full_page_intlv(); run_case(3'b111, 1'b1, 3'b010, 1'b0, 1'b0); endtask
  task automatic test_reserved_cl();     run_case(3'b001, 1'b0, 3'b100, 1'b1, 1'b0); endtask
  task automatic test_reserved_bl();     run_case(3'b100, 1'b0, 3'b011, 1'b0, 1'b0); endtask

  initial begin
    test_seq_bl8_cl2();
    test_full_page_seq();
    test_interleaved_bl4();
    test_full_page_intlv();
    test_reserved_cl();
    test_reserved_bl();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule